// File: doc/BRIEF.md
# Interrupt Register Front-End

This block sits between a byte-wide processor access port and a host chipset's single interrupt request input. It keeps an 8-bit pending register of device interrupts and a primary enable set. Device-side logic raises or drops groups of pending bits through two vector inputs. The processor masks lines, acknowledges one interrupt by number and reads the pending state, including an 8-byte read of the pending register.

A fixed set of companion addresses is decoded alongside. A secondary controller whose status always reads zero and whose mask is only stored. Two DMA mode bytes that are kept. A speaker status byte that mirrors an external timer output. Several stub locations (keyboard, DMA command, DMA mask, DMA reset, secondary acknowledge) that take writes and ignore them. Illegal accesses finish normally but raise an error flag.

Every access takes one cycle. The response (ready, error, read data) is registered. The request line is registered too and reflects each state change one clock edge after the change.

Top module: `irq_regfront`

## Requirements
- R1: After reset `irq_req`, `acc_ready` and `acc_err` are 0, the pending register reads 0x00 and the primary mask (address 0x01) reads 0xFF, so every line is masked.
- R2: `irq_req` is 1 exactly when some pending bit is set whose enable is set, and it follows every pending or mask change one clock edge later.
- R3: A 1-byte write to address 0x01 stores the complement of the data as the enable set (a written 1 masks that line). A 1-byte read of 0x01 returns the value last written.
- R4: A 1-byte write to address 0x02 clears pending bit n, where n is data bits [3:0]. Values 8 to 15 and the upper nibble change nothing.
- R5: `src_set` ORs into the pending register and `src_clr` clears the bits it names. When a set meets a clear or an acknowledge of the same bit in one cycle, the bit ends up set.
- R6: A 1-byte read of address 0x03 (secondary status) returns 0x00. A 1-byte write to 0x04 (secondary mask) is stored and reads back from 0x04 unchanged, and it never alters `irq_req`.
- R7: A 1-byte read of address 0x05 returns 0x20 while `tmr2_hi` is 1 and 0x00 while it is 0. Writes to 0x05 change no readable state.
- R8: Size code in `acc_size`: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. An 8-byte read is legal only at address 0x00 and returns the pending byte zero-extended. Any other 8-byte access, any 2- or 4-byte access, a read of a write-only or unknown address, and a write to 0x00, 0x03 or an unknown address raise `acc_err` with read data 0 and no state change.
- R9: 1-byte writes to 0x08 to 0x0F (keyboard, DMA commands, DMA masks, DMA resets, secondary acknowledge) finish without error and without effect. Writes to 0x06 and 0x07 (DMA mode A/B) are stored and read back.
- R10: `acc_ready` is 1 for exactly the cycle after each cycle with `acc_valid`. `acc_err` and `acc_rdata` are valid in that cycle, and `acc_rdata` is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Register offset |
| acc_size | input | 2 | Access size code |
| acc_wdata | input | 8 | Write byte |
| acc_ready | output | 1 | Access complete pulse |
| acc_err | output | 1 | Access was illegal |
| acc_rdata | output | 64 | Registered read data |
| src_set | input | 8 | Device-side pending set vector |
| src_clr | input | 8 | Device-side pending clear vector |
| tmr2_hi | input | 1 | External timer channel output level |
| irq_req | output | 1 | Interrupt request toward the host |

## Verification
Every result of this block is due one clock edge after its stimulus. Ready, error and read data follow the access edge. The request line follows the edge that changed the pending register or the mask. The bench drives all inputs, including the device vectors and the timer level, on a falling edge and samples every output on the next falling edge, after exactly one rising edge. Its model applies the same stimulus to its state in that same step, so each comparison covers one single registered stage.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_PEND     = 8'h00;
  localparam logic [ADDR_W-1:0] A_MASK     = 8'h01;
  localparam logic [ADDR_W-1:0] A_ACK      = 8'h02;
  localparam logic [ADDR_W-1:0] A_SEC_STAT = 8'h03;
  localparam logic [ADDR_W-1:0] A_SEC_MASK = 8'h04;
  localparam logic [ADDR_W-1:0] A_SPKR     = 8'h05;
  localparam logic [ADDR_W-1:0] A_MODE_A   = 8'h06;
  localparam logic [ADDR_W-1:0] A_MODE_B   = 8'h07;
  localparam logic [ADDR_W-1:0] A_KBD      = 8'h08;
  localparam logic [ADDR_W-1:0] A_DCMD_A   = 8'h09;
  localparam logic [ADDR_W-1:0] A_DCMD_B   = 8'h0A;
  localparam logic [ADDR_W-1:0] A_DMSK_A   = 8'h0B;
  localparam logic [ADDR_W-1:0] A_DMSK_B   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_DRST_A   = 8'h0D;
  localparam logic [ADDR_W-1:0] A_DRST_B   = 8'h0E;
  localparam logic [ADDR_W-1:0] A_SEC_ACK  = 8'h0F;

  localparam logic [1:0] SZ_1 = 2'd0;
  localparam logic [1:0] SZ_8 = 2'd3;

  typedef enum logic [2:0] {
    RS_ZERO, RS_PEND, RS_MASK, RS_SEC_MASK, RS_SPKR, RS_MODE_A, RS_MODE_B
  } rsel_e;

  typedef struct packed {
    logic mask_pri;
    logic ack;
    logic mask_sec;
    logic mode_a;
    logic mode_b;
  } wstb_t;
endpackage

// File: rtl/irqf_decode.sv
module irqf_decode
  import irqf_pkg::*;
(
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  output wstb_t             wstb,
  output rsel_e             rsel,
  output logic              err
);
  always_comb begin
    wstb = '0;
    rsel = RS_ZERO;
    err  = 1'b0;
    if (acc_valid) begin
      if (acc_write) begin
        if (acc_size != SZ_1) begin
          err = 1'b1;
        end else begin
          case (acc_addr)
            A_MASK:     wstb.mask_pri = 1'b1;
            A_ACK:      wstb.ack      = 1'b1;
            A_SEC_MASK: wstb.mask_sec = 1'b1;
            A_MODE_A:   wstb.mode_a   = 1'b1;
            A_MODE_B:   wstb.mode_b   = 1'b1;
            A_SPKR, A_KBD, A_DCMD_A, A_DCMD_B, A_DMSK_A, A_DMSK_B,
            A_DRST_A, A_DRST_B, A_SEC_ACK: ;
            default:    err = 1'b1;
          endcase
        end
      end else if (acc_size == SZ_8) begin
        if (acc_addr == A_PEND) rsel = RS_PEND;
        else                    err  = 1'b1;
      end else if (acc_size != SZ_1) begin
        err = 1'b1;
      end else begin
        case (acc_addr)
          A_PEND:     rsel = RS_PEND;
          A_MASK:     rsel = RS_MASK;
          A_SEC_STAT: rsel = RS_ZERO;
          A_SEC_MASK: rsel = RS_SEC_MASK;
          A_SPKR:     rsel = RS_SPKR;
          A_MODE_A:   rsel = RS_MODE_A;
          A_MODE_B:   rsel = RS_MODE_B;
          default:    err  = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqf_regs.sv
module irqf_regs
  import irqf_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ACK_IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wstb_t             wstb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] src_set,
  input  logic [DATA_W-1:0] src_clr,
  output logic [DATA_W-1:0] pend,
  output logic [DATA_W-1:0] en,
  output logic [DATA_W-1:0] sec_mask,
  output logic [DATA_W-1:0] mode_a,
  output logic [DATA_W-1:0] mode_b,
  output logic              irq_req
);
  logic [DATA_W-1:0] ack_vec, pend_nxt, en_nxt;
  logic              pend_ld, irq_nxt;

  for (genvar i = 0; i < DATA_W; i++) begin : g_ack
    assign ack_vec[i] = wstb.ack && (wdata[ACK_IDX_W-1:0] == ACK_IDX_W'(i));
  end

  always_comb begin
    pend_ld  = (|src_set) || (|src_clr) || wstb.ack;
    pend_nxt = (pend & ~src_clr & ~ack_vec) | src_set;
    en_nxt   = wstb.mask_pri ? ~wdata : en;
    irq_nxt  = |(pend_nxt & en_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      en       <= '0;
      sec_mask <= '0;
      mode_a   <= '0;
      mode_b   <= '0;
      irq_req  <= 1'b0;
    end else begin
      if (pend_ld)       pend     <= pend_nxt;
      if (wstb.mask_pri) en       <= en_nxt;
      if (wstb.mask_sec) sec_mask <= wdata;
      if (wstb.mode_a)   mode_a   <= wdata;
      if (wstb.mode_b)   mode_b   <= wdata;
      irq_req <= irq_nxt;
    end
  end

  p_irq_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (|(pend & en)));
  p_mask_inverts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.mask_pri |=> en == ~$past(wdata));
  p_ack_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wstb.ack && src_set == '0) |=> (pend & ~$past(pend)) == '0);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != '0) |=> (pend & $past(src_set)) == $past(src_set));
  p_clr_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_clr & ~src_set) != '0) |=> (pend & $past(src_clr & ~src_set)) == '0);
  p_sec_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.mask_sec |=> $stable(en));
endmodule

// File: rtl/irqf_resp.sv
module irqf_resp
  import irqf_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RD_W     = 64,
  parameter int unsigned SPKR_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  rsel_e             rsel,
  input  logic              err,
  input  logic [DATA_W-1:0] pend,
  input  logic [DATA_W-1:0] en,
  input  logic [DATA_W-1:0] sec_mask,
  input  logic [DATA_W-1:0] mode_a,
  input  logic [DATA_W-1:0] mode_b,
  input  logic              spkr_in,
  output logic              ready,
  output logic              err_q,
  output logic [RD_W-1:0]   rdata
);
  logic [RD_W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    case (rsel)
      RS_PEND:     rd_nxt[DATA_W-1:0] = pend;
      RS_MASK:     rd_nxt[DATA_W-1:0] = ~en;
      RS_SEC_MASK: rd_nxt[DATA_W-1:0] = sec_mask;
      RS_SPKR:     rd_nxt[SPKR_BIT]   = spkr_in;
      RS_MODE_A:   rd_nxt[DATA_W-1:0] = mode_a;
      RS_MODE_B:   rd_nxt[DATA_W-1:0] = mode_b;
      default:     rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      err_q <= 1'b0;
      rdata <= '0;
    end else begin
      ready <= acc_valid;
      err_q <= err;
      rdata <= rd_nxt;
    end
  end

  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ready);
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!ready && !err_q && rdata == '0));
  p_err_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> rdata == '0);
endmodule

// File: rtl/irq_regfront.sv
module irq_regfront
  import irqf_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RD_W      = 64,
  parameter int unsigned ACK_IDX_W = 4,
  parameter int unsigned SPKR_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_ready,
  output logic              acc_err,
  output logic [RD_W-1:0]   acc_rdata,
  input  logic [DATA_W-1:0] src_set,
  input  logic [DATA_W-1:0] src_clr,
  input  logic              tmr2_hi,
  output logic              irq_req
);
  logic [1:0] rst_pipe;
  logic       rst_sn;
  wstb_t      wstb;
  rsel_e      rsel;
  logic       dec_err;
  logic [DATA_W-1:0] pend, en, sec_mask, mode_a, mode_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  irqf_decode u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .wstb      (wstb),
    .rsel      (rsel),
    .err       (dec_err)
  );

  irqf_regs #(.DATA_W(DATA_W), .ACK_IDX_W(ACK_IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wstb     (wstb),
    .wdata    (acc_wdata),
    .src_set  (src_set),
    .src_clr  (src_clr),
    .pend     (pend),
    .en       (en),
    .sec_mask (sec_mask),
    .mode_a   (mode_a),
    .mode_b   (mode_b),
    .irq_req  (irq_req)
  );

  irqf_resp #(.DATA_W(DATA_W), .RD_W(RD_W), .SPKR_BIT(SPKR_BIT)) u_resp (
    .clk       (clk),
    .rst_n     (rst_sn),
    .acc_valid (acc_valid),
    .rsel      (rsel),
    .err       (dec_err),
    .pend      (pend),
    .en        (en),
    .sec_mask  (sec_mask),
    .mode_a    (mode_a),
    .mode_b    (mode_b),
    .spkr_in   (tmr2_hi),
    .ready     (acc_ready),
    .err_q     (acc_err),
    .rdata     (acc_rdata)
  );
endmodule

// File: tb/irq_regfront_bench.sv
module irq_regfront_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [7:0]  acc_addr = '0, acc_wdata = '0;
  logic [1:0]  acc_size = '0;
  logic        acc_ready, acc_err, irq_req;
  logic [63:0] acc_rdata;
  logic [7:0]  src_set = '0, src_clr = '0;
  logic        tmr2_hi = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_pend = '0, m_mask = 8'hFF, m_sec = '0, m_ma = '0, m_mb = '0;

  always #5 clk = ~clk;

  irq_regfront u_irq_regfront (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_ready(acc_ready), .acc_err(acc_err), .acc_rdata(acc_rdata),
    .src_set(src_set), .src_clr(src_clr), .tmr2_hi(tmr2_hi), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit wr_ok(input logic [7:0] a);
    return (a >= 8'h01 && a <= 8'h02) || (a >= 8'h04 && a <= 8'h0F);
  endfunction

  // {err, rdata} expected for an access against the current model state
  function automatic logic [64:0] exp_resp(input bit v, input bit w, input logic [7:0] a,
                                           input logic [1:0] s, input bit spk);
    if (!v) return '0;
    if (w) return {(s != 2'd0) || !wr_ok(a), 64'd0};
    if (s == 2'd3) return (a == 8'h00) ? {1'b0, 56'd0, m_pend} : {1'b1, 64'd0};
    if (s != 2'd0) return {1'b1, 64'd0};
    case (a)
      8'h00: return {1'b0, 56'd0, m_pend};
      8'h01: return {1'b0, 56'd0, m_mask};
      8'h03: return '0;
      8'h04: return {1'b0, 56'd0, m_sec};
      8'h05: return {1'b0, 56'd0, spk ? 8'h20 : 8'h00};
      8'h06: return {1'b0, 56'd0, m_ma};
      8'h07: return {1'b0, 56'd0, m_mb};
      default: return {1'b1, 64'd0};
    endcase
  endfunction

  task automatic cyc(input string tag, input bit v, input bit w, input logic [7:0] a,
                     input logic [1:0] s, input logic [7:0] d, input logic [7:0] st,
                     input logic [7:0] cl, input bit spk);
    logic [64:0] er;
    logic [7:0]  ackv;
    er = exp_resp(v, w, a, s, spk);
    acc_valid = v; acc_write = w; acc_addr = a; acc_size = s; acc_wdata = d;
    src_set = st; src_clr = cl; tmr2_hi = spk;
    @(posedge clk);
    @(negedge clk);
    ackv = '0;
    if (v && w && !er[64]) begin
      case (a)
        8'h01: m_mask = d;
        8'h02: if (d[3:0] < 4'd8) ackv = 8'(1) << d[3:0];
        8'h04: m_sec = d;
        8'h06: m_ma = d;
        8'h07: m_mb = d;
        default: ;
      endcase
    end
    m_pend = (m_pend & ~cl & ~ackv) | st;
    acc_valid = 1'b0; src_set = '0; src_clr = '0;
    chk({tag, " ready R10"}, {63'd0, acc_ready}, {63'd0, v});
    chk({tag, " err R8"}, {63'd0, acc_err}, {63'd0, er[64]});
    chk({tag, " rdata R10"}, acc_rdata, er[63:0]);
    chk({tag, " irq R2"}, {63'd0, irq_req}, {63'd0, |(m_pend & ~m_mask)});
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7713);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset irq", {63'd0, irq_req}, 64'd0);
    chk("R1 reset ready", {63'd0, acc_ready}, 64'd0);
    chk("R1 reset err", {63'd0, acc_err}, 64'd0);
    cyc("R1 mask read", 1, 0, 8'h01, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R1 pend read", 1, 0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R10 idle", 0, 0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    // R2 / R5: pending but masked, then unmask
    cyc("R5 set", 0, 0, 8'h00, 2'd0, 8'h00, 8'h05, 8'h00, 0);
    cyc("R3 unmask bit0", 1, 1, 8'h01, 2'd0, 8'hFE, 8'h00, 8'h00, 0);
    cyc("R3 mask readback", 1, 0, 8'h01, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R3 unmask bit2", 1, 1, 8'h01, 2'd0, 8'hFA, 8'h00, 8'h00, 0);
    // R4 acknowledges
    cyc("R4 ack 0", 1, 1, 8'h02, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R4 ack nibble 0xA", 1, 1, 8'h02, 2'd0, 8'h1A, 8'h00, 8'h00, 0);
    cyc("R4 ack upper nibble", 1, 1, 8'h02, 2'd0, 8'h32, 8'h00, 8'h00, 0);
    cyc("R4 pend read", 1, 0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    // R5 set wins
    cyc("R5 set+clr same bit", 1, 0, 8'h00, 2'd0, 8'h00, 8'h08, 8'h08, 0);
    cyc("R5 pend after tie", 1, 0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R5 clr", 0, 0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h08, 0);
    cyc("R5 set vs ack", 1, 1, 8'h02, 2'd0, 8'h01, 8'h02, 8'h00, 0);
    cyc("R5 pend after ack tie", 1, 0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    // R6 secondary
    cyc("R6 sec status", 1, 0, 8'h03, 2'd0, 8'h00, 8'hFF, 8'h00, 0);
    cyc("R6 sec mask write", 1, 1, 8'h04, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R6 sec mask read", 1, 0, 8'h04, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R6 sec mask write2", 1, 1, 8'h04, 2'd0, 8'h5A, 8'h00, 8'h00, 0);
    cyc("R6 sec mask read2", 1, 0, 8'h04, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    // R7 speaker
    cyc("R7 spkr high", 1, 0, 8'h05, 2'd0, 8'h00, 8'h00, 8'h00, 1);
    cyc("R7 spkr low", 1, 0, 8'h05, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R7 spkr write", 1, 1, 8'h05, 2'd0, 8'hFF, 8'h00, 8'h00, 0);
    cyc("R7 mask after spkr write", 1, 0, 8'h01, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    // R8 sizes and errors
    cyc("R8 clr all", 0, 0, 8'h00, 2'd0, 8'h00, 8'h00, 8'hFF, 0);
    cyc("R8 set 0x81", 0, 0, 8'h00, 2'd0, 8'h00, 8'h81, 8'h00, 0);
    cyc("R8 wide pend", 1, 0, 8'h00, 2'd3, 8'h00, 8'h00, 8'h00, 0);
    cyc("R8 wide mask", 1, 0, 8'h01, 2'd3, 8'h00, 8'h00, 8'h00, 0);
    cyc("R8 half pend", 1, 0, 8'h00, 2'd1, 8'h00, 8'h00, 8'h00, 0);
    cyc("R8 unknown read", 1, 0, 8'h10, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R8 ack read", 1, 0, 8'h02, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R8 pend write", 1, 1, 8'h00, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R8 word mask write", 1, 1, 8'h01, 2'd2, 8'h00, 8'h00, 8'h00, 0);
    cyc("R8 mask unchanged", 1, 0, 8'h01, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R8 pend unchanged", 1, 0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    // R9 stubs and mode registers
    for (int a = 8; a < 16; a++)
      cyc("R9 stub write", 1, 1, 8'(a), 2'd0, 8'hFF, 8'h00, 8'h00, 0);
    cyc("R9 pend after stubs", 1, 0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R9 mode A write", 1, 1, 8'h06, 2'd0, 8'h3C, 8'h00, 8'h00, 0);
    cyc("R9 mode B write", 1, 1, 8'h07, 2'd0, 8'hC3, 8'h00, 8'h00, 0);
    cyc("R9 mode A read", 1, 0, 8'h06, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    cyc("R9 mode B read", 1, 0, 8'h07, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] ra, rd, rs, rc;
      logic [1:0] rz;
      ra = 8'($urandom_range(0, 17));
      rz = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      rd = 8'($urandom);
      rs = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      rc = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      cyc("R2 random", 1'($urandom), 1'($urandom), ra, rz, rd, rs, rc, 1'($urandom));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule